// File: doc/BRIEF.md
# Paged Register Access Controller

This block decodes host reads and writes into a small I/O window of byte-wide registers. A control register holds a page number and two one-shot request bits. One request bit asks for a board reset and the other asks for an interrupt reset. The page number decides where the low offsets of the window land. On page 0 they reach the timer channel registers and raise a per-register select strobe. On any other page they reach a placeholder bank with one set of registers for each page, and the timer never sees them.

The page number is written through the control register and read back at a separate read-only offset. A write that carries a reset request fires that request and leaves the page as it was. A write without a request loads the page and fires nothing. A board reset pulse returns every register to zero except the page, so the host keeps its place in the window.

Read data is registered. Selects and reset pulses are registered too, so each appears in the clock after the access that caused it.

Top module: `paged_reg_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the page is 0 and read data, select strobes and both reset pulses are 0.
- R2: A write to offset 8 with bits 7 and 6 both 0 loads bits [1:0] into the page and raises neither reset pulse. A read of offset 8 returns the page in bits [1:0] with every other bit 0.
- R3: A write to offset 8 with bit 7 set drives the board reset output high for exactly the next clock cycle and leaves the page unchanged.
- R4: A write to offset 8 with bit 6 set drives the interrupt reset output high for exactly the next clock cycle and leaves the page unchanged. With bits 7 and 6 both set, both pulses fire together.
- R5: A read of offset 7 returns the page in bits [1:0] with every other bit 0. Writes to offset 7 change nothing.
- R6: On page 0, a read or write of offset k (0 to 3) sets select bit k, and only that bit, for the next cycle. It reads or writes timer register k.
- R7: On pages 1 to 3, offsets 0 to 3 raise no select bit and leave the timer registers untouched. They read and write a placeholder register that belongs to that page and offset.
- R8: Offsets 4, 5, 6 and 9 to 15 read as 0x00, and writes to them change no register.
- R9: Read data appears in the cycle after the read strobe. In any cycle that does not follow a read strobe, read data is 0x00.
- R10: While the board reset pulse is high, all timer and placeholder registers clear to 0 at the next edge, and a write in that cycle is dropped. The page keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register offset within the window |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_data_o | output | 8 | Registered read data |
| tmr_sel_o | output | 4 | Per-timer-register select, one-hot, one cycle after the access |
| brd_rst_o | output | 1 | Board reset pulse |
| irq_rst_o | output | 1 | Interrupt reset pulse |

## Verification
The bench goes after the aliasing between pages. It fills the same low offset on several pages and then returns to page 0. A decoder that ignored the page would overwrite the timer register or return the wrong page's byte. Request writes are given page bits that differ from the stored page, so a design that loaded the page regardless of the request bits would show a changed readback at offset 7. The bench also writes to the timer registers during the board reset pulse and reads them afterwards, which catches a wrong clear priority. Back-to-back reads with idle gaps catch read data that is late by one cycle or held when it should return to zero.

// File: rtl/prc_pkg.sv
package prc_pkg;

   // Kind of target an access lands on after page-aware decoding
   typedef enum logic [2:0] {
      DEC_NONE = 3'd0,
      DEC_TMR  = 3'd1,
      DEC_BANK = 3'd2,
      DEC_MISC = 3'd3,
      DEC_PAGE = 3'd4
   } prc_dec_e;

endpackage

// File: rtl/prc_decode.sv
module prc_decode
   import prc_pkg::*;
#(
   parameter int ADDR_W       = 4,
   parameter int PAGE_W       = 2,
   parameter int NUM_TMR_REGS = 4,
   parameter int MISC_OFS     = 8,
   parameter int PAGE_RD_OFS  = 7,
   parameter int TMR_IDX_W    = 2
) (
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [PAGE_W-1:0]    page_i,
   output prc_dec_e             kind_o,
   output logic [TMR_IDX_W-1:0] idx_o
);

   localparam logic [ADDR_W-1:0] MISC_A  = ADDR_W'(MISC_OFS);
   localparam logic [ADDR_W-1:0] PGRD_A  = ADDR_W'(PAGE_RD_OFS);
   localparam logic [ADDR_W-1:0] TMR_LIM = ADDR_W'(NUM_TMR_REGS);

   generate
      if (TMR_IDX_W > ADDR_W) begin : g_bad_idx
         $error("prc_decode: index wider than address");
      end
   endgenerate

   logic low_window;
   logic page_zero;

   assign low_window = (addr_i < TMR_LIM);
   assign page_zero  = (page_i == '0);
   assign idx_o      = addr_i[TMR_IDX_W-1:0];

   always_comb begin
      kind_o = DEC_NONE;
      if (addr_i == MISC_A) begin
         kind_o = DEC_MISC;
      end else if (addr_i == PGRD_A) begin
         kind_o = DEC_PAGE;
      end else if (low_window) begin
         kind_o = page_zero ? DEC_TMR : DEC_BANK;
      end
   end

endmodule

// File: rtl/prc_misc_ctl.sv
module prc_misc_ctl #(
   parameter int DATA_W  = 8,
   parameter int PAGE_W  = 2,
   parameter int IRQ_BIT = 6,
   parameter int BRD_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [PAGE_W-1:0] page_o,
   output logic              brd_pulse_o,
   output logic              irq_pulse_o
);

   logic req_brd;
   logic req_irq;
   logic page_load;

   assign req_brd   = wdata_i[BRD_BIT];
   assign req_irq   = wdata_i[IRQ_BIT];
   // any request bit turns the write into a pure request; the page field is ignored
   assign page_load = wr_hit_i && !req_brd && !req_irq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_o <= '0;
      end else if (page_load) begin
         page_o <= wdata_i[PAGE_W-1:0];
      end
   end

   // request bits are never stored: each lives for one cycle as a strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brd_pulse_o <= 1'b0;
         irq_pulse_o <= 1'b0;
      end else begin
         brd_pulse_o <= wr_hit_i && req_brd;
         irq_pulse_o <= wr_hit_i && req_irq;
      end
   end

endmodule

// File: rtl/prc_reg_bank.sv
module prc_reg_bank #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 4,
   parameter int IDX_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  ridx_i,
   output logic [DATA_W-1:0] rdata_o
);

   generate
      if ((1 << IDX_W) < NUM_REGS) begin : g_bad_w
         $error("prc_reg_bank: index too narrow");
      end
   endgenerate

   logic [DATA_W-1:0] regs_q [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs_q[g] <= '0;
            end else if (clr_i) begin
               regs_q[g] <= '0;
            end else if (we_i && (widx_i == IDX_W'(g))) begin
               regs_q[g] <= wdata_i;
            end
         end
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (ridx_i == IDX_W'(i)) begin
            rdata_o = regs_q[i];
         end
      end
   end

endmodule

// File: rtl/paged_reg_ctrl.sv
module paged_reg_ctrl
   import prc_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 4,
   parameter int NUM_PAGES    = 4,
   parameter int NUM_TMR_REGS = 4,
   parameter int MISC_OFS     = 8,
   parameter int PAGE_RD_OFS  = 7,
   parameter int IRQ_BIT      = 6,
   parameter int BRD_BIT      = 7,
   parameter bit HOLD_RDATA   = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   input  logic                    rd_en_i,
   input  logic                    wr_en_i,
   output logic [DATA_W-1:0]       rd_data_o,
   output logic [NUM_TMR_REGS-1:0] tmr_sel_o,
   output logic                    brd_rst_o,
   output logic                    irq_rst_o
);

   localparam int PAGE_W     = $clog2(NUM_PAGES);
   localparam int TMR_IDX_W  = $clog2(NUM_TMR_REGS);
   localparam int BANK_REGS  = (NUM_PAGES - 1) * NUM_TMR_REGS;
   localparam int BANK_IDX_W = $clog2(BANK_REGS);

   // elaboration-time parameter checks
   generate
      if (NUM_PAGES < 2 || (1 << PAGE_W) != NUM_PAGES) begin : g_bad_pages
         $error("paged_reg_ctrl: page count must be a power of two, at least 2");
      end
      if (NUM_TMR_REGS < 2) begin : g_bad_tmr
         $error("paged_reg_ctrl: need at least two timer registers");
      end
      if (NUM_TMR_REGS > MISC_OFS || NUM_TMR_REGS > PAGE_RD_OFS) begin : g_bad_map
         $error("paged_reg_ctrl: timer window overlaps control offsets");
      end
      if (MISC_OFS == PAGE_RD_OFS || MISC_OFS >= (1 << ADDR_W) ||
          PAGE_RD_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
         $error("paged_reg_ctrl: control offsets invalid");
      end
      if (IRQ_BIT == BRD_BIT || IRQ_BIT < PAGE_W || BRD_BIT < PAGE_W ||
          IRQ_BIT >= DATA_W || BRD_BIT >= DATA_W) begin : g_bad_bits
         $error("paged_reg_ctrl: request bits clash with page field");
      end
   endgenerate

   prc_dec_e               dec_kind;
   logic [TMR_IDX_W-1:0]   tmr_idx;
   logic [PAGE_W-1:0]      page_q;
   logic                   brd_pulse;
   logic                   irq_pulse;
   logic [DATA_W-1:0]      tmr_rdata;
   logic [DATA_W-1:0]      bank_rdata;
   logic [DATA_W-1:0]      rd_next;
   logic [BANK_IDX_W-1:0]  bank_idx;
   int                     bank_lin;
   logic                   access;

   assign access = rd_en_i || wr_en_i;

   prc_decode #(
      .ADDR_W      (ADDR_W),
      .PAGE_W      (PAGE_W),
      .NUM_TMR_REGS(NUM_TMR_REGS),
      .MISC_OFS    (MISC_OFS),
      .PAGE_RD_OFS (PAGE_RD_OFS),
      .TMR_IDX_W   (TMR_IDX_W)
   ) u_dec (
      .addr_i(addr_i),
      .page_i(page_q),
      .kind_o(dec_kind),
      .idx_o (tmr_idx)
   );

   prc_misc_ctl #(
      .DATA_W (DATA_W),
      .PAGE_W (PAGE_W),
      .IRQ_BIT(IRQ_BIT),
      .BRD_BIT(BRD_BIT)
   ) u_misc (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit_i   (wr_en_i && (dec_kind == DEC_MISC)),
      .wdata_i    (wdata_i),
      .page_o     (page_q),
      .brd_pulse_o(brd_pulse),
      .irq_pulse_o(irq_pulse)
   );

   prc_reg_bank #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_TMR_REGS),
      .IDX_W   (TMR_IDX_W)
   ) u_tmr_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (brd_pulse),
      .we_i   (wr_en_i && (dec_kind == DEC_TMR)),
      .widx_i (tmr_idx),
      .wdata_i(wdata_i),
      .ridx_i (tmr_idx),
      .rdata_o(tmr_rdata)
   );

   // placeholder bank: pages 1..NUM_PAGES-1 laid out one after another
   always_comb begin
      bank_lin = (int'(page_q) - 1) * NUM_TMR_REGS + int'(tmr_idx);
      bank_idx = BANK_IDX_W'(bank_lin);
   end

   prc_reg_bank #(
      .DATA_W  (DATA_W),
      .NUM_REGS(BANK_REGS),
      .IDX_W   (BANK_IDX_W)
   ) u_page_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (brd_pulse),
      .we_i   (wr_en_i && (dec_kind == DEC_BANK)),
      .widx_i (bank_idx),
      .wdata_i(wdata_i),
      .ridx_i (bank_idx),
      .rdata_o(bank_rdata)
   );

   always_comb begin
      unique case (dec_kind)
         DEC_TMR:           rd_next = tmr_rdata;
         DEC_BANK:          rd_next = bank_rdata;
         DEC_MISC,
         DEC_PAGE:          rd_next = {{(DATA_W-PAGE_W){1'b0}}, page_q};
         default:           rd_next = '0;
      endcase
   end

   // read data register: variant chosen by HOLD_RDATA
   generate
      if (HOLD_RDATA) begin : g_rd_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_data_o <= '0;
            end else if (rd_en_i) begin
               rd_data_o <= rd_next;
            end
         end
      end else begin : g_rd_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_data_o <= '0;
            end else begin
               rd_data_o <= rd_en_i ? rd_next : '0;
            end
         end
      end
   endgenerate

   // one select flop per timer register
   generate
      for (genvar s = 0; s < NUM_TMR_REGS; s++) begin : g_sel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tmr_sel_o[s] <= 1'b0;
            end else begin
               tmr_sel_o[s] <= access && (dec_kind == DEC_TMR) &&
                               (tmr_idx == TMR_IDX_W'(s));
            end
         end
      end
   endgenerate

   assign brd_rst_o = brd_pulse;
   assign irq_rst_o = irq_pulse;

endmodule

// File: rtl/prc_chk.sv
module prc_chk #(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 4,
   parameter int PAGE_W       = 2,
   parameter int NUM_TMR_REGS = 4,
   parameter int MISC_OFS     = 8,
   parameter int PAGE_RD_OFS  = 7,
   parameter int IRQ_BIT      = 6,
   parameter int BRD_BIT      = 7,
   parameter bit HOLD_RDATA   = 1'b0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       addr_i,
   input logic [DATA_W-1:0]       wdata_i,
   input logic                    rd_en_i,
   input logic                    wr_en_i,
   input logic [DATA_W-1:0]       rd_data_o,
   input logic [NUM_TMR_REGS-1:0] tmr_sel_o,
   input logic                    brd_rst_o,
   input logic                    irq_rst_o,
   input logic [PAGE_W-1:0]       page
);

   localparam logic [ADDR_W-1:0] MISC_A = ADDR_W'(MISC_OFS);
   localparam logic [ADDR_W-1:0] PGRD_A = ADDR_W'(PAGE_RD_OFS);

   logic misc_wr;
   assign misc_wr = wr_en_i && (addr_i == MISC_A);

   // R2
   page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (misc_wr && !wdata_i[BRD_BIT] && !wdata_i[IRQ_BIT])
         |=> (page == $past(wdata_i[PAGE_W-1:0])));

   // R3
   brd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brd_rst_o |-> $past(misc_wr && wdata_i[BRD_BIT]));

   // R3
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (misc_wr && (wdata_i[BRD_BIT] || wdata_i[IRQ_BIT])) |=> $stable(page));

   // R4
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rst_o |-> $past(misc_wr && wdata_i[IRQ_BIT]));

   // R5
   page_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && (addr_i == PGRD_A))
         |=> (rd_data_o == {{(DATA_W-PAGE_W){1'b0}}, $past(page)}));

   // R6
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tmr_sel_o));

   // R7
   sel_page0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|tmr_sel_o) |-> ($past(page) == '0));

   generate
      if (!HOLD_RDATA) begin : g_idle
         // R9
         rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rd_en_i) |-> (rd_data_o == '0));
      end
   endgenerate

endmodule

bind paged_reg_ctrl prc_chk #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .PAGE_W      (PAGE_W),
   .NUM_TMR_REGS(NUM_TMR_REGS),
   .MISC_OFS    (MISC_OFS),
   .PAGE_RD_OFS (PAGE_RD_OFS),
   .IRQ_BIT     (IRQ_BIT),
   .BRD_BIT     (BRD_BIT),
   .HOLD_RDATA  (HOLD_RDATA)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr_i   (addr_i),
   .wdata_i  (wdata_i),
   .rd_en_i  (rd_en_i),
   .wr_en_i  (wr_en_i),
   .rd_data_o(rd_data_o),
   .tmr_sel_o(tmr_sel_o),
   .brd_rst_o(brd_rst_o),
   .irq_rst_o(irq_rst_o),
   .page     (page_q)
);

// File: tb/paged_reg_ctrl_tb_top.sv
module paged_reg_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] rd_data;
   logic [3:0] tmr_sel;
   logic       brd_rst;
   logic       irq_rst;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   paged_reg_ctrl dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (addr),
      .wdata_i  (wdata),
      .rd_en_i  (rd_en),
      .wr_en_i  (wr_en),
      .rd_data_o(rd_data),
      .tmr_sel_o(tmr_sel),
      .brd_rst_o(brd_rst),
      .irq_rst_o(irq_rst)
   );

   // ---------------- behavioural reference model ----------------
   int m_page = 0;
   int m_tmr [4] = '{0, 0, 0, 0};
   int m_bank [4][4];
   int m_rd = 0;
   int m_sel = 0;
   int m_brd = 0;
   int m_irq = 0;
   int m_clr;
   int ma;
   int md;

   function automatic int model_read(int a);
      if (a == 8 || a == 7) return m_page;
      if (a < 4) return (m_page == 0) ? m_tmr[a] : m_bank[m_page][a];
      return 0;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 4; i++) begin
         m_tmr[i] = 0;
         for (int p = 0; p < 4; p++) m_bank[p][i] = 0;
      end
   endtask

   initial model_clear();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_page = 0; m_rd = 0; m_sel = 0; m_brd = 0; m_irq = 0;
         model_clear();
      end else begin
         m_clr = m_brd;
         ma = int'(addr);
         md = int'(wdata);
         m_rd  = rd_en ? model_read(ma) : 0;
         m_sel = ((rd_en || wr_en) && m_page == 0 && ma < 4) ? (1 << ma) : 0;
         m_brd = (wr_en && ma == 8 && ((md >> 7) & 1) == 1) ? 1 : 0;
         m_irq = (wr_en && ma == 8 && ((md >> 6) & 1) == 1) ? 1 : 0;
         if (wr_en && ma < 4 && m_clr == 0) begin
            if (m_page == 0) m_tmr[ma] = md;
            else m_bank[m_page][ma] = md;
         end
         if (m_clr != 0) model_clear();
         if (wr_en && ma == 8 && ((md >> 6) & 3) == 0) m_page = md & 3;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         chk(cur_req, "rd_data", int'(rd_data), m_rd);
         chk(cur_req, "tmr_sel", int'(tmr_sel), m_sel);
         chk(cur_req, "brd_rst", int'(brd_rst), m_brd);
         chk(cur_req, "irq_rst", int'(irq_rst), m_irq);
      end
   end

   task automatic do_wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(int a, int exp, string req);
      @(negedge clk);
      rd_en = 1'b1; addr = 4'(a);
      @(negedge clk);
      rd_en = 1'b0;
      chk(req, "directed read", int'(rd_data), exp);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      chk("R1", "page during reset", int'(rd_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "sel after reset", int'(tmr_sel), 0);
      do_rd(7, 0, "R1");
      for (int i = 0; i < 4; i++) do_rd(i, 0, "R1");

      // R6: timer registers on page 0 with select strobes
      cur_req = "R6";
      for (int i = 0; i < 4; i++) begin
         do_wr(i, 8'h10 + i * 8'h11);
      end
      for (int i = 0; i < 4; i++) begin
         do_rd(i, 8'h10 + i * 8'h11, "R6");
         chk("R6", "sel onehot", int'(tmr_sel), 1 << i);
      end

      // R8: unmapped offsets
      cur_req = "R8";
      do_wr(5, 8'hAA);
      do_wr(12, 8'h55);
      do_rd(5, 0, "R8");
      do_rd(12, 0, "R8");
      do_rd(15, 0, "R8");
      do_rd(2, 8'h32, "R8");

      // R2: page load through offset 8
      cur_req = "R2";
      do_wr(8, 8'h02);
      chk("R2", "no brd pulse", int'(brd_rst), 0);
      do_rd(8, 2, "R2");
      do_rd(7, 2, "R5");

      // R7: placeholder bank on other pages
      cur_req = "R7";
      do_wr(1, 8'h5A);
      chk("R7", "no sel off page 0", int'(tmr_sel), 0);
      do_rd(1, 8'h5A, "R7");
      do_wr(8, 8'h01);
      do_wr(1, 8'h33);
      do_rd(1, 8'h33, "R7");
      do_wr(8, 8'h03);
      do_rd(1, 0, "R7");
      do_wr(8, 8'h02);
      do_rd(1, 8'h5A, "R7");
      do_wr(8, 8'h00);
      do_rd(1, 8'h21, "R7");

      // R5: page readback offset ignores writes
      cur_req = "R5";
      do_wr(7, 8'h03);
      do_rd(7, 0, "R5");

      // R3 / R10: board reset request keeps page, clears registers
      cur_req = "R3";
      do_wr(8, 8'h01);
      do_wr(1, 8'h77);
      do_wr(8, 8'h83);
      chk("R3", "brd pulse", int'(brd_rst), 1);
      @(negedge clk);
      chk("R3", "brd pulse ends", int'(brd_rst), 0);
      do_rd(7, 1, "R3");
      cur_req = "R10";
      do_rd(1, 0, "R10");
      do_wr(8, 8'h00);
      do_rd(0, 0, "R10");
      // write landing in the pulse cycle is dropped
      do_wr(0, 8'h44);
      @(negedge clk);
      wr_en = 1'b1; addr = 4'd8; wdata = 8'h80;
      @(negedge clk);
      addr = 4'd0; wdata = 8'h99;
      chk("R10", "pulse cycle", int'(brd_rst), 1);
      @(negedge clk);
      wr_en = 1'b0;
      do_rd(0, 0, "R10");
      do_rd(7, 0, "R10");

      // R4: interrupt reset request, and both at once
      cur_req = "R4";
      do_wr(8, 8'h02);
      do_wr(8, 8'h41);
      chk("R4", "irq pulse", int'(irq_rst), 1);
      chk("R4", "no brd pulse", int'(brd_rst), 0);
      do_rd(7, 2, "R4");
      do_wr(8, 8'hC3);
      chk("R4", "both irq", int'(irq_rst), 1);
      chk("R4", "both brd", int'(brd_rst), 1);
      do_rd(7, 2, "R4");

      // R9: back-to-back reads then idle
      cur_req = "R9";
      do_wr(8, 8'h00);
      do_wr(3, 8'hE1);
      @(negedge clk);
      rd_en = 1'b1; addr = 4'd3;
      @(negedge clk);
      addr = 4'd7;
      chk("R9", "first of pair", int'(rd_data), 8'hE1);
      @(negedge clk);
      rd_en = 1'b0;
      chk("R9", "second of pair", int'(rd_data), 0);
      @(negedge clk);
      chk("R9", "idle zero", int'(rd_data), 0);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule